// File: doc/BRIEF.md
# DRAM Training Phase Sequencer

This block orders the training of a DRAM interface once device initialization has finished. There are three phases, always taken in the same order: write leveling, then read strobe gate training, then read data eye training. For each phase the block does one of two things. It can start an external search engine with a coarse seed delay and keep the per-lane delays the engine reports. Or it can skip the search and load a fixed per-lane compensation delay into that phase's output register. The search algorithms themselves live in those external engines. Each engine talks to the sequencer through a start pulse, a done/fail pair and a per-lane result bus.

Software or an init controller sets the memory type code, three per-phase enable bits, the seed and fixed delays and a wait limit. It then pulses `start`. The block copies the whole configuration at that moment. Write leveling is always skipped for the two memory types that lack it. When the last phase completes, the block raises `seq_done` for one cycle. When an engine fails or times out, it raises `seq_done` and `seq_err` together and reports the phase that failed.

Controller states: `S_IDLE` (waiting for start), `S_PHASE` (decide the current phase: kick its engine or load its fixed delay), `S_WAIT` (wait for the engine's done), `S_DONE` (one-cycle success report) and `S_FAIL` (one-cycle error report). Transitions:
- `S_IDLE`→`S_PHASE` on start.
- `S_PHASE`→`S_WAIT` when the phase is active.
- `S_PHASE`→`S_PHASE` when the phase is skipped and is not the last.
- `S_PHASE`→`S_DONE` when the last phase is skipped.
- `S_WAIT`→`S_PHASE` or `S_DONE` on a good done, depending on whether the phase was the last.
- `S_WAIT`→`S_FAIL` on a reported failure or a timeout.
- `S_DONE`/`S_FAIL`→`S_IDLE` always.

Top module: `dram_train_seq`

## Requirements
- R1: Engine starts occur only in ascending phase index order: 0 = write leveling, 1 = gate training, 2 = eye training. No two engine starts are ever active in the same cycle.
- R2: Each phase p has its own enable bit, `phase_en[p]`. An active phase raises `eng_start[p]` for exactly one cycle. During that cycle, `eng_seed` carries that phase's seed lanes. Lane l of phase p sits at bits `[p*LANES*DLY_W + l*DLY_W +: DLY_W]` of `seed_dly`, `fixed_dly`, `eng_result` and `dly_out`.
- R3: When `eng_done[p]` is sampled high with `eng_fail[p]` low, phase p's slice of `eng_result` is copied into phase p's slice of `dly_out`.
- R4: A phase that is not active starts no engine. It loads its `fixed_dly` slice into `dly_out` and occupies exactly one cycle.
- R5: The type code is 0 = DDR2, 1 = DDR3, 2 = DDR3L, 3 = LPDDR2. For codes 0 and 3, write leveling is forced inactive whatever `phase_en[0]` says. For codes 1 and 2, all three phases follow their enables.
- R6: `seq_done` is a one-cycle pulse. Counting the cycle after the start edge as cycle 1, it comes in cycle S + A·(1+W) + 1. Here S is the number of skipped phases, A the number of active phases and W the wait cycles each engine needs.
- R7: A done sampled together with fail ends the sequence. `seq_done` and `seq_err` pulse together and `err_phase` holds the failing index. No later phase is started.
- R8: After a kick, an engine must report done within `timeout_cyc` wait cycles (the limit is at least 1). Otherwise the sequence ends in error with `err_phase` naming that phase.
- R9: Type, enables, seeds, fixed delays and the limit are copied at start. A `start` pulse or a configuration change while a sequence runs has no effect on that sequence.
- R10: After reset, `dly_out`, `eng_start`, `seq_done`, `seq_err` and `seq_busy` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a sequence |
| dram_type | input | 2 | Memory type code |
| phase_en | input | 3 | Per-phase search enables |
| seed_dly | input | 3*LANES*DLY_W | Per-phase, per-lane seed delays |
| fixed_dly | input | 3*LANES*DLY_W | Per-phase, per-lane bypass delays |
| timeout_cyc | input | TO_W | Maximum engine wait in cycles |
| eng_start | output | 3 | Per-engine start pulse |
| eng_seed | output | LANES*DLY_W | Seed lanes of the phase being kicked |
| eng_done | input | 3 | Per-engine completion |
| eng_fail | input | 3 | Per-engine failure, valid with done |
| eng_result | input | 3*LANES*DLY_W | Per-engine result lanes |
| dly_out | output | 3*LANES*DLY_W | Final per-phase, per-lane delays |
| seq_busy | output | 1 | A sequence is in progress |
| seq_done | output | 1 | Sequence end pulse |
| seq_err | output | 1 | Sequence ended in error (with seq_done) |
| err_phase | output | 2 | Index of the failing phase |

## Verification
The hardest case to reach is the exact edge of the timeout window. An engine that replies in its last allowed wait cycle must be accepted. One that replies a single cycle later must be cut off, even though its done pulse still arrives while the block is reporting the failure. The bench's engine model takes a programmable reply latency. It runs a lone eye-training phase with latency equal to the limit and then with one cycle more. A separate run toggles the enables, the type and `start` in the middle of a sequence. This shows that only the copied configuration steers the phases.

// File: rtl/dts_pkg.sv
package dts_pkg;

    localparam int NUM_PH = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PHASE,
        S_WAIT,
        S_DONE,
        S_FAIL
    } seq_state_t;

    localparam logic [1:0] TYPE_DDR2   = 2'd0;
    localparam logic [1:0] TYPE_DDR3   = 2'd1;
    localparam logic [1:0] TYPE_DDR3L  = 2'd2;
    localparam logic [1:0] TYPE_LPDDR2 = 2'd3;

    localparam logic [1:0] PH_LAST = 2'd2;

    function automatic logic wl_capable(input logic [1:0] t);
        return (t == TYPE_DDR3) || (t == TYPE_DDR3L);
    endfunction

endpackage

// File: rtl/dts_phase_pick.sv
module dts_phase_pick #(
    parameter int W = 32
) (
    input  logic [3*W-1:0] vec,
    input  logic [1:0]     sel,
    output logic [W-1:0]   pick
);

    logic [W-1:0] parts [3];

    for (genvar g = 0; g < 3; g++) begin : g_part
        assign parts[g] = vec[g*W +: W];
    end

    always_comb begin
        unique case (sel)
            2'd0:    pick = parts[0];
            2'd1:    pick = parts[1];
            default: pick = parts[2];
        endcase
    end

endmodule

// File: rtl/dts_wait_timer.sv
module dts_wait_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);

    logic [TO_W-1:0] cnt;

    assign expired = run && (cnt == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: the wait count never passes the programmed limit
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && limit != '0) |-> (cnt < limit));

endmodule

// File: rtl/dram_train_seq.sv
module dram_train_seq
    import dts_pkg::*;
#(
    parameter  int LANES = 4,
    parameter  int DLY_W = 8,
    parameter  int TO_W  = 16,
    localparam int PW    = LANES * DLY_W,
    localparam int VW    = NUM_PH * PW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      dram_type,
    input  logic [2:0]      phase_en,
    input  logic [VW-1:0]   seed_dly,
    input  logic [VW-1:0]   fixed_dly,
    input  logic [TO_W-1:0] timeout_cyc,
    output logic [2:0]      eng_start,
    output logic [PW-1:0]   eng_seed,
    input  logic [2:0]      eng_done,
    input  logic [2:0]      eng_fail,
    input  logic [VW-1:0]   eng_result,
    output logic [VW-1:0]   dly_out,
    output logic            seq_busy,
    output logic            seq_done,
    output logic            seq_err,
    output logic [1:0]      err_phase
);

    seq_state_t state, state_nx;

    logic [1:0]      ph;
    logic [1:0]      cfg_type;
    logic [2:0]      cfg_eff;
    logic [VW-1:0]   cfg_seed;
    logic [VW-1:0]   cfg_fixed;
    logic [TO_W-1:0] cfg_to;
    logic [VW-1:0]   dly_q;
    logic [1:0]      errph_q;

    logic [PW-1:0] sel_seed;
    logic [PW-1:0] sel_fixed;
    logic [PW-1:0] sel_res;
    logic          cur_en;
    logic          done_now;
    logic          fail_now;
    logic          last_ph;
    logic          tmo;

    dts_phase_pick #(.W(PW)) u_pick_seed (
        .vec  (cfg_seed),
        .sel  (ph),
        .pick (sel_seed)
    );

    dts_phase_pick #(.W(PW)) u_pick_fixed (
        .vec  (cfg_fixed),
        .sel  (ph),
        .pick (sel_fixed)
    );

    dts_phase_pick #(.W(PW)) u_pick_res (
        .vec  (eng_result),
        .sel  (ph),
        .pick (sel_res)
    );

    dts_wait_timer #(.TO_W(TO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state == S_PHASE),
        .run     (state == S_WAIT),
        .limit   (cfg_to),
        .expired (tmo)
    );

    assign cur_en   = cfg_eff[ph];
    assign done_now = eng_done[ph];
    assign fail_now = eng_fail[ph];
    assign last_ph  = (ph == PH_LAST);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_PHASE;
            S_PHASE: begin
                if (cur_en)       state_nx = S_WAIT;
                else if (last_ph) state_nx = S_DONE;
                else              state_nx = S_PHASE;
            end
            S_WAIT: begin
                if (done_now) begin
                    if (fail_now)     state_nx = S_FAIL;
                    else if (last_ph) state_nx = S_DONE;
                    else              state_nx = S_PHASE;
                end else if (tmo) begin
                    state_nx = S_FAIL;
                end
            end
            S_DONE:  state_nx = S_IDLE;
            S_FAIL:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // configuration capture, phase index and delay registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph        <= '0;
            cfg_type  <= '0;
            cfg_eff   <= '0;
            cfg_seed  <= '0;
            cfg_fixed <= '0;
            cfg_to    <= '0;
            dly_q     <= '0;
            errph_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        ph        <= '0;
                        cfg_type  <= dram_type;
                        cfg_eff   <= phase_en & {2'b11, wl_capable(dram_type)};
                        cfg_seed  <= seed_dly;
                        cfg_fixed <= fixed_dly;
                        cfg_to    <= timeout_cyc;
                        errph_q   <= '0;
                    end
                end
                S_PHASE: begin
                    if (!cur_en) begin
                        dly_q[ph*PW +: PW] <= sel_fixed;
                        if (!last_ph) ph <= ph + 2'd1;
                    end
                end
                S_WAIT: begin
                    if (done_now && !fail_now) begin
                        dly_q[ph*PW +: PW] <= sel_res;
                        if (!last_ph) ph <= ph + 2'd1;
                    end else if (done_now || tmo) begin
                        errph_q <= ph;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        eng_start = '0;
        if (state == S_PHASE && cur_en) eng_start = 3'b001 << ph;
        eng_seed  = sel_seed;
        dly_out   = dly_q;
        seq_busy  = (state != S_IDLE);
        seq_done  = (state == S_DONE) || (state == S_FAIL);
        seq_err   = (state == S_FAIL);
        err_phase = errph_q;
    end

    assert_start_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_start));

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start != 3'b000) |=> (eng_start == 3'b000));

    assert_wl_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start[0] |-> wl_capable(cfg_type));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> seq_done);

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> ($stable(cfg_eff) && $stable(cfg_seed) && $stable(cfg_fixed)));

endmodule

// File: tb/dram_train_seq_test.sv
module dram_train_seq_test;

    localparam int LANES = 4;
    localparam int DLY_W = 8;
    localparam int TO_W  = 16;
    localparam int PW    = LANES * DLY_W;
    localparam int VW    = 3 * PW;

    // {type[7:6], enables[5:3], expected active mask[2:0]}
    localparam logic [7:0] VEC [32] = '{
        8'h00, 8'h08, 8'h12, 8'h1A, 8'h24, 8'h2C, 8'h36, 8'h3E,
        8'h40, 8'h49, 8'h52, 8'h5B, 8'h64, 8'h6D, 8'h76, 8'h7F,
        8'h80, 8'h89, 8'h92, 8'h9B, 8'hA4, 8'hAD, 8'hB6, 8'hBF,
        8'hC0, 8'hC8, 8'hD2, 8'hDA, 8'hE4, 8'hEC, 8'hF6, 8'hFE
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      dram_type = '0;
    logic [2:0]      phase_en = '0;
    logic [VW-1:0]   seed_dly;
    logic [VW-1:0]   fixed_dly;
    logic [TO_W-1:0] timeout_cyc = 16'd100;
    logic [2:0]      eng_start;
    logic [PW-1:0]   eng_seed;
    logic [2:0]      eng_done = '0;
    logic [2:0]      eng_fail = '0;
    logic [VW-1:0]   eng_result = '0;
    logic [VW-1:0]   dly_out;
    logic            seq_busy, seq_done, seq_err;
    logic [1:0]      err_phase;

    int total = 0;
    int fails = 0;

    // engine model controls and log
    int lat = 2;
    int fail_ph = -1;
    int n_starts = 0;
    int start_log [4];
    logic [PW-1:0] seen_seed [3];
    logic [2:0] pend = '0;
    int left [3] = '{0, 0, 0};

    always #2.5 clk = ~clk;

    dram_train_seq #(.LANES(LANES), .DLY_W(DLY_W), .TO_W(TO_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dram_type(dram_type),
        .phase_en(phase_en), .seed_dly(seed_dly), .fixed_dly(fixed_dly),
        .timeout_cyc(timeout_cyc), .eng_start(eng_start), .eng_seed(eng_seed),
        .eng_done(eng_done), .eng_fail(eng_fail), .eng_result(eng_result),
        .dly_out(dly_out), .seq_busy(seq_busy), .seq_done(seq_done),
        .seq_err(seq_err), .err_phase(err_phase)
    );

    function automatic logic [7:0] seed_of(int p, int l);
        return 8'(8'h20 + 16 * p + l);
    endfunction

    function automatic logic [7:0] fixed_of(int p, int l);
        return 8'(8'hA0 + 16 * p + l);
    endfunction

    function automatic logic [PW-1:0] plus3(logic [PW-1:0] s);
        logic [PW-1:0] r;
        for (int l = 0; l < LANES; l++) r[l*DLY_W +: DLY_W] = s[l*DLY_W +: DLY_W] + 8'd3;
        return r;
    endfunction

    // abstract training engines
    always @(negedge clk) begin
        eng_done <= '0;
        eng_fail <= '0;
        for (int p = 0; p < 3; p++) begin
            if (pend[p]) begin
                if (left[p] <= 1) begin
                    eng_done[p] <= 1'b1;
                    eng_fail[p] <= (fail_ph == p);
                    eng_result[p*PW +: PW] <= plus3(seen_seed[p]);
                    pend[p] <= 1'b0;
                end else begin
                    left[p] <= left[p] - 1;
                end
            end
            if (eng_start[p]) begin
                if (n_starts < 4) start_log[n_starts] = p;
                n_starts = n_starts + 1;
                seen_seed[p] = eng_seed;
                pend[p] <= 1'b1;
                left[p] <= lat;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // runs one sequence; when disturb is set, changes inputs and re-pulses start mid-run
    task automatic run_seq(input logic [1:0] t, input logic [2:0] e, input bit disturb,
                           output int cycles);
        int k;
        @(negedge clk);
        n_starts  = 0;
        dram_type = t;
        phase_en  = e;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!seq_done && k < 300) begin
            @(negedge clk);
            k++;
            if (disturb && k == 3) begin
                phase_en  = 3'b000;
                dram_type = 2'd0;
                fixed_dly = ~fixed_dly;
                start     = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        cycles = k;
    endtask

    // compares all phase slices against the expected source for an active mask
    task automatic chk_outputs(input logic [2:0] act, input string req);
        for (int p = 0; p < 3; p++) begin
            for (int l = 0; l < LANES; l++) begin
                logic [7:0] exp_v;
                exp_v = act[p] ? 8'(seed_of(p, l) + 8'd3) : fixed_of(p, l);
                chk(dly_out[p*PW + l*DLY_W +: DLY_W] == exp_v, req,
                    int'(dly_out[p*PW + l*DLY_W +: DLY_W]), int'(exp_v));
            end
        end
    endtask

    task automatic chk_order(input logic [2:0] act, input string req);
        int n;
        int idx;
        n = 0;
        for (int p = 0; p < 3; p++) if (act[p]) n++;
        chk(n_starts == n, req, n_starts, n);
        idx = 0;
        for (int p = 0; p < 3; p++) begin
            if (act[p] && idx < 4 && idx < n_starts) begin
                chk(start_log[idx] == p, req, start_log[idx], p);
                chk(seen_seed[p] == seed_dly[p*PW +: PW], "R2 seed",
                    int'(seen_seed[p][7:0]), int'(seed_dly[p*PW +: 8]));
                idx++;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int cyc;
        int na;
        logic [1:0] t;
        logic [2:0] e;
        logic [2:0] act;

        for (int p = 0; p < 3; p++)
            for (int l = 0; l < LANES; l++) begin
                seed_dly[p*PW + l*DLY_W +: DLY_W]  = seed_of(p, l);
                fixed_dly[p*PW + l*DLY_W +: DLY_W] = fixed_of(p, l);
            end

        repeat (3) @(negedge clk);
        // R10 reset state
        chk(dly_out == '0, "R10 dly_out", int'(dly_out[31:0]), 0);
        chk(eng_start == '0 && !seq_done && !seq_err && !seq_busy, "R10 flags",
            int'({eng_start, seq_done, seq_err, seq_busy}), 0);
        rst_n = 1'b1;

        // table: every type and every enable combination (R1 R2 R3 R4 R5 R6)
        lat = 2;
        for (int i = 0; i < 32; i++) begin
            t   = VEC[i][7:6];
            e   = VEC[i][5:3];
            act = VEC[i][2:0];
            run_seq(t, e, 1'b0, cyc);
            na = int'(act[0]) + int'(act[1]) + int'(act[2]);
            chk(seq_done && !seq_err, "R6 done no err", int'({seq_done, seq_err}), 2);
            chk(cyc == (3 - na) + na * (1 + lat) + 1, "R6 timing", cyc, (3 - na) + na * 3 + 1);
            chk_order(act, "R1 R5 order");
            chk_outputs(act, "R3 R4 delay source");
            @(negedge clk);
            chk(!seq_done, "R6 pulse", int'(seq_done), 0);
        end

        // R7: gate engine fails
        fail_ph = 1;
        run_seq(2'd1, 3'b111, 1'b0, cyc);
        chk(seq_done && seq_err, "R7 err", int'({seq_done, seq_err}), 3);
        chk(err_phase == 2'd1, "R7 phase", int'(err_phase), 1);
        chk(cyc == 7, "R7 timing", cyc, 7);
        chk(n_starts == 2, "R7 no later start", n_starts, 2);
        chk(dly_out[0 +: 8] == 8'(seed_of(0, 0) + 8'd3), "R7 earlier kept",
            int'(dly_out[0 +: 8]), int'(seed_of(0, 0) + 8'd3));
        repeat (6) @(negedge clk);
        chk(n_starts == 2, "R7 no later start", n_starts, 2);
        fail_ph = -1;

        // R8: reply in the last allowed wait cycle
        timeout_cyc = 16'd4;
        lat = 4;
        run_seq(2'd1, 3'b100, 1'b0, cyc);
        chk(seq_done && !seq_err, "R8 in time", int'({seq_done, seq_err}), 2);
        chk(cyc == 8, "R8 timing", cyc, 8);
        chk(dly_out[2*PW +: 8] == 8'(seed_of(2, 0) + 8'd3), "R8 result",
            int'(dly_out[2*PW +: 8]), int'(seed_of(2, 0) + 8'd3));

        // R8: reply one cycle too late
        lat = 5;
        run_seq(2'd1, 3'b100, 1'b0, cyc);
        chk(seq_done && seq_err, "R8 late", int'({seq_done, seq_err}), 3);
        chk(err_phase == 2'd2, "R8 phase", int'(err_phase), 2);
        chk(cyc == 8, "R8 err timing", cyc, 8);
        repeat (4) @(negedge clk);
        chk(!seq_busy && !seq_done, "R8 idle after", int'({seq_busy, seq_done}), 0);
        timeout_cyc = 16'd100;
        lat = 2;

        // R9: inputs changed and start re-pulsed mid-run
        run_seq(2'd1, 3'b111, 1'b1, cyc);
        fixed_dly = ~fixed_dly;
        chk(seq_done && !seq_err, "R9 done", int'({seq_done, seq_err}), 2);
        chk(cyc == 10, "R9 timing", cyc, 10);
        chk_order(3'b111, "R9 order");
        chk_outputs(3'b111, "R9 captured cfg");
        repeat (3) @(negedge clk);
        chk(!seq_busy, "R9 no restart", int'(seq_busy), 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule